// File: doc/BRIEF.md
# Dual-Match Multichannel PWM Timer

The block is a timer built around one shared up-counter, with six pulse outputs and four capture inputs. A prescaler sets how often the counter steps. A period value sets the last count before the counter returns to zero. Each output has two compare values. When the count reaches the first one, the output goes high. When the count reaches the second one, the output goes low. A pulse can therefore begin and end anywhere in the cycle, including a pulse that spans the wrap point. Each capture input is synchronised and edge-detected. On its selected edge, it copies the counter into a register that can only be read.

Software uses a simple single-cycle register port for access. Writes land on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The timer core has a mode decode with two modes:
- TM_IDLE: enable is clear. The counter and prescaler are held at zero.
- TM_RUN: enable is set. The counter advances, and it wraps after reaching the period.

In TM_RUN, each output channel chooses one action per clock:
- CH_OFF when idle.
- CH_CLEAR when the count equals its deactivation value.
- CH_SET when the count equals its activation value.
- CH_HOLD otherwise.

The precedence of these actions is the transition order. Register map (word addresses), with 16-bit fields zero-extended to 32 bits:

| Address | Content |
|---------|---------|
| 0x00 | control, bit 0 = enable |
| 0x01 | capture configuration |
| 0x02 | period |
| 0x03 | prescale |
| 0x04 | count (read-only) |
| 0x08+i | activation value of output i |
| 0x10+i | deactivation value of output i |
| 0x18+k | capture value of input k (read-only) |

Top module: `dmpwm_timer`

## Requirements
- R1: After reset, period (0x02) and prescale (0x03) read 0x0000FFFF. Count, all match values, all captures, control and capture configuration read 0, and all outputs are low.
- R2: While enabled with prescale value P, the counter changes only on every (P+1)-th clock. With P=0 it changes every clock.
- R3: On a step, the counter goes from its value to value+1. When its value is at or above the period register, it goes to 0 instead, so it runs 0..period.
- R4: On the clock edge where the count equals an output's activation value (and not its deactivation value), that output becomes 1 from the edge on. On the edge where the count equals its deactivation value, it becomes 0. Otherwise it holds.
- R5: When an output's activation and deactivation values are equal and the count reaches them, the output is driven (or stays) low.
- R6: While control bit 0 is 0, every output is 0 one clock later, and count reads 0.
- R7: Capture input k has a 2-bit field at bits [2k+1:2k] of 0x01: 01 rising, 10 falling, 11 both edges. The input passes two synchronising flops and an edge detector. The capture register takes the counter value held just before the third rising clock edge after the input change.
- R8: A write to a match, period or prescale register is used from the clock after the write edge.
- R9: Writes to the count address (0x04) and the capture addresses (0x18+k) change nothing.
- R10: A capture channel whose field is 00 never updates its register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | write strobe, one write per high cycle |
| reg_addr | input | 6 | register word address for read and write |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | combinational read data for reg_addr |
| cap_in | input | 4 | asynchronous capture event inputs |
| pwm_out | output | 6 | registered PWM outputs |

## Verification
The bench targets the following corner cases:
- **Equal match values.** A design that let activation win would emit a one-clock glitch on the output.
- **A pulse whose deactivation value lies below its activation value.** A wrong compare would never wrap the pulse across zero.
- **A period written below the current count.** A counter that wrapped only on equality would run on to 0xFFFF.

It also looks for the following faults:
- The prescaler off by one.
- A capture synchroniser one flop short, which latches a different count value.
- A capture field of 00 that still captures.
- Writes to read-only addresses that corrupt state.

// File: rtl/dmpwm_pkg.sv
package dmpwm_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    typedef enum logic {
        TM_IDLE,
        TM_RUN
    } tmr_mode_t;

    typedef enum logic [1:0] {
        CH_HOLD,
        CH_SET,
        CH_CLEAR,
        CH_OFF
    } ch_act_t;
endpackage

// File: rtl/dmpwm_tick.sv
module dmpwm_tick
    import dmpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] prd,
    input  logic [CW-1:0] psc,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] pre;
    tmr_mode_t     mode;
    logic          step;

    always_comb mode = en ? TM_RUN : TM_IDLE;
    always_comb step = (pre >= psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            pre <= '0;
        end else begin
            unique case (mode)
                TM_IDLE: begin
                    cnt <= '0;
                    pre <= '0;
                end
                TM_RUN: begin
                    if (step) begin
                        pre <= '0;
                        cnt <= (cnt >= prd) ? '0 : cnt + CW'(1);
                    end else begin
                        pre <= pre + CW'(1);
                    end
                end
            endcase
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0)); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) || cnt == '0)); // R3
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pre < psc) |=> (cnt == $past(cnt))); // R2
endmodule

// File: rtl/dmpwm_chan.sv
module dmpwm_chan
    import dmpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] act,
    input  logic [CW-1:0] deact,
    output logic          out
);
    ch_act_t sel;

    always_comb begin
        if (!en)                sel = CH_OFF;
        else if (cnt == deact)  sel = CH_CLEAR;
        else if (cnt == act)    sel = CH_SET;
        else                    sel = CH_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out <= 1'b0;
        end else begin
            unique case (sel)
                CH_OFF, CH_CLEAR: out <= 1'b0;
                CH_SET:           out <= 1'b1;
                CH_HOLD:          out <= out;
            endcase
        end
    end

    AST_TIE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == act && cnt == deact) |=> !out); // R5
    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == act && cnt != deact) |=> out); // R4
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out); // R6
endmodule

// File: rtl/dmpwm_capture.sv
module dmpwm_capture
    import dmpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg,
    input  logic [CW-1:0] cnt,
    input  logic          evt_in,
    output logic [CW-1:0] cap
);
    logic      s1, s2, s3;
    logic      rise, fall, hit;
    edge_sel_t mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= evt_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        rise = s2 & ~s3;
        fall = ~s2 & s3;
        mode = edge_sel_t'(cfg);
        unique case (mode)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cap <= '0;
        else if (hit) cap <= cnt;
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap)); // R7
    AST_CAP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b00) |=> $stable(cap)); // R10
endmodule

// File: rtl/dmpwm_timer.sv
module dmpwm_timer
    import dmpwm_pkg::*;
#(
    parameter int NOUT = 6,
    parameter int NCAP = 4,
    parameter int CW   = 16,
    parameter int DW   = 32,
    parameter int AW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NCAP-1:0] cap_in,
    output logic [NOUT-1:0] pwm_out
);
    localparam int A_CTRL   = 0;
    localparam int A_CAPCFG = 1;
    localparam int A_PRD    = 2;
    localparam int A_PSC    = 3;
    localparam int A_CNT    = 4;
    localparam int A_ACT    = 8;
    localparam int A_DEACT  = 16;
    localparam int A_CAPT   = 24;
    localparam int CFGW     = 2 * NCAP;

    logic            en_q;
    logic [CFGW-1:0] capcfg_q;
    logic [CW-1:0]   prd_q, psc_q, cnt;
    logic [CW-1:0]   act_q   [NOUT];
    logic [CW-1:0]   deact_q [NOUT];
    logic [CW-1:0]   cap_q   [NCAP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            capcfg_q <= '0;
            prd_q    <= '1;
            psc_q    <= '1;
            for (int i = 0; i < NOUT; i++) begin
                act_q[i]   <= '0;
                deact_q[i] <= '0;
            end
        end else if (reg_wr) begin
            if (reg_addr == AW'(A_CTRL))   en_q     <= reg_wdata[0];
            if (reg_addr == AW'(A_CAPCFG)) capcfg_q <= reg_wdata[CFGW-1:0];
            if (reg_addr == AW'(A_PRD))    prd_q    <= reg_wdata[CW-1:0];
            if (reg_addr == AW'(A_PSC))    psc_q    <= reg_wdata[CW-1:0];
            for (int i = 0; i < NOUT; i++) begin
                if (reg_addr == AW'(A_ACT + i))   act_q[i]   <= reg_wdata[CW-1:0];
                if (reg_addr == AW'(A_DEACT + i)) deact_q[i] <= reg_wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_CTRL))   reg_rdata = DW'(en_q);
        if (reg_addr == AW'(A_CAPCFG)) reg_rdata = DW'(capcfg_q);
        if (reg_addr == AW'(A_PRD))    reg_rdata = DW'(prd_q);
        if (reg_addr == AW'(A_PSC))    reg_rdata = DW'(psc_q);
        if (reg_addr == AW'(A_CNT))    reg_rdata = DW'(cnt);
        for (int i = 0; i < NOUT; i++) begin
            if (reg_addr == AW'(A_ACT + i))   reg_rdata = DW'(act_q[i]);
            if (reg_addr == AW'(A_DEACT + i)) reg_rdata = DW'(deact_q[i]);
        end
        for (int k = 0; k < NCAP; k++) begin
            if (reg_addr == AW'(A_CAPT + k)) reg_rdata = DW'(cap_q[k]);
        end
    end

    dmpwm_tick #(.CW(CW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .prd(prd_q), .psc(psc_q), .cnt(cnt)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        dmpwm_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_q), .cnt(cnt),
            .act(act_q[g]), .deact(deact_q[g]), .out(pwm_out[g])
        );
    end

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        dmpwm_capture #(.CW(CW)) u_cap (
            .clk(clk), .rst_n(rst_n), .cfg(capcfg_q[2*g +: 2]), .cnt(cnt),
            .evt_in(cap_in[g]), .cap(cap_q[g])
        );
    end

    AST_RESET_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(A_CNT)) |=> (cnt == '0 || !en_q || cnt != 16'hFFFF || prd_q == 16'hFFFF)); // R9
endmodule

// File: tb/dmpwm_timer_test.sv
module dmpwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  cap_in = '0;
    logic [5:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dmpwm_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .pwm_out(pwm_out)
    );

    // reference state, built from the requirements
    logic        m_en;
    logic [7:0]  m_cfg;
    logic [15:0] m_prd, m_psc, m_cnt, m_pre;
    logic [15:0] m_act [6];
    logic [15:0] m_deact [6];
    logic [15:0] m_cap [4];
    logic [5:0]  m_out;
    logic [3:0]  m_s1, m_s2, m_s3;

    function automatic logic [15:0] next_count(logic [15:0] c, logic [15:0] p);
        return (c >= p) ? 16'd0 : c + 16'd1;   // R3
    endfunction

    function automatic logic next_out(logic en, logic [15:0] c, logic [15:0] a,
                                      logic [15:0] d, logic cur);
        if (!en) return 1'b0;                  // R6
        if (c == d) return 1'b0;               // R4, R5
        if (c == a) return 1'b1;
        return cur;
    endfunction

    function automatic logic cap_hit(logic [1:0] cfg, logic now, logic old);
        case (cfg)
            2'b01:   return now & ~old;
            2'b10:   return ~now & old;
            2'b11:   return now ^ old;
            default: return 1'b0;              // R10
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [5:0] a);
        if (a == 6'h00) return {31'd0, m_en};
        if (a == 6'h01) return {24'd0, m_cfg};
        if (a == 6'h02) return {16'd0, m_prd};
        if (a == 6'h03) return {16'd0, m_psc};
        if (a == 6'h04) return {16'd0, m_cnt};
        if (a >= 6'h08 && a < 6'h0E) return {16'd0, m_act[a - 6'h08]};
        if (a >= 6'h10 && a < 6'h16) return {16'd0, m_deact[a - 6'h10]};
        if (a >= 6'h18 && a < 6'h1C) return {16'd0, m_cap[a - 6'h18]};
        return 32'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_cfg <= 0; m_prd <= 16'hFFFF; m_psc <= 16'hFFFF;
            m_cnt <= 0; m_pre <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            for (int i = 0; i < 6; i++) begin m_act[i] <= 0; m_deact[i] <= 0; end
            for (int k = 0; k < 4; k++) m_cap[k] <= 0;
        end else begin
            if (m_en) begin
                if (m_pre >= m_psc) begin       // R2
                    m_pre <= 0;
                    m_cnt <= next_count(m_cnt, m_prd);
                end else begin
                    m_pre <= m_pre + 16'd1;
                end
            end else begin
                m_pre <= 0;
                m_cnt <= 0;
            end
            for (int i = 0; i < 6; i++)
                m_out[i] <= next_out(m_en, m_cnt, m_act[i], m_deact[i], m_out[i]);
            m_s1 <= cap_in; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int k = 0; k < 4; k++)
                if (cap_hit(m_cfg[2*k +: 2], m_s2[k], m_s3[k])) m_cap[k] <= m_cnt; // R7
            if (reg_wr) begin                   // R8, R9
                if (reg_addr == 6'h00) m_en  <= reg_wdata[0];
                if (reg_addr == 6'h01) m_cfg <= reg_wdata[7:0];
                if (reg_addr == 6'h02) m_prd <= reg_wdata[15:0];
                if (reg_addr == 6'h03) m_psc <= reg_wdata[15:0];
                for (int i = 0; i < 6; i++) begin
                    if (reg_addr == 6'(8 + i))  m_act[i]   <= reg_wdata[15:0];
                    if (reg_addr == 6'(16 + i)) m_deact[i] <= reg_wdata[15:0];
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        chk(pwm_out == m_out, "R4 outputs", {26'd0, pwm_out}, {26'd0, m_out});
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp_read(a), tag, reg_rdata, exp_read(a));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        reg_addr = 6'h02; #1; chk(reg_rdata == 32'hFFFF, "R1 period", reg_rdata, 32'hFFFF);
        reg_addr = 6'h03; #1; chk(reg_rdata == 32'hFFFF, "R1 prescale", reg_rdata, 32'hFFFF);
        reg_addr = 6'h04; #1; chk(reg_rdata == 32'h0, "R1 count", reg_rdata, 32'h0);
        reg_addr = 6'h0A; #1; chk(reg_rdata == 32'h0, "R1 match", reg_rdata, 32'h0);
        reg_addr = 6'h15; #1; chk(reg_rdata == 32'h0, "R1 match", reg_rdata, 32'h0);
        reg_addr = 6'h1B; #1; chk(reg_rdata == 32'h0, "R1 capture", reg_rdata, 32'h0);
        chk(pwm_out == 6'd0, "R1 outputs", {26'd0, pwm_out}, 32'd0);

        // R3, R4, R5 with no prescale
        wr(6'h03, 0); wr(6'h02, 9);
        wr(6'h08, 2); wr(6'h10, 6);
        wr(6'h09, 3); wr(6'h11, 3);
        wr(6'h0A, 7); wr(6'h12, 1);
        wr(6'h00, 1);
        for (int i = 0; i < 40; i++) begin
            cycle();
            chk(pwm_out[1] == 1'b0, "R5 tie stays low", {31'd0, pwm_out[1]}, 32'd0);
            chk(m_cnt <= 16'd9, "R3 range", {16'd0, m_cnt}, 32'd9);
            rd(6'h04, "R3 count");
        end

        // R2 prescale
        wr(6'h03, 3);
        for (int i = 0; i < 30; i++) begin cycle(); rd(6'h04, "R2 count"); end

        // R8 immediate update, period below current count
        wr(6'h08, 5);
        run(5);
        wr(6'h03, 0);
        run(7);
        wr(6'h02, 2);
        for (int i = 0; i < 12; i++) begin cycle(); rd(6'h04, "R8 count"); end
        wr(6'h02, 20);

        // R9 writes to read-only addresses
        wr(6'h04, 32'h1234); rd(6'h04, "R9 count");
        wr(6'h18, 32'h00AB); rd(6'h18, "R9 capture");

        // R7, R10 captures
        wr(6'h01, 32'b00_11_10_01);
        for (int i = 0; i < 8; i++) begin
            cap_in = cap_in ^ 4'b1111;
            run(4 + i);
            for (int k = 0; k < 4; k++) rd(6'(24 + k), "R7 capture");
            reg_addr = 6'h1B; #1;
            chk(reg_rdata == 32'd0, "R10 disabled capture", reg_rdata, 32'd0);
        end

        // R6 disable
        wr(6'h00, 0);
        cycle();
        chk(pwm_out == 6'd0, "R6 outputs low", {26'd0, pwm_out}, 32'd0);
        reg_addr = 6'h04; #1;
        chk(reg_rdata == 32'd0, "R6 count zero", reg_rdata, 32'd0);
        run(5);
        wr(6'h00, 1);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 19) == 0) begin
                int sel = $urandom_range(0, 9);
                if (sel == 0)      wr(6'h00, ($urandom_range(0, 7) != 0) ? 32'd1 : 32'd0);
                else if (sel == 1) wr(6'h02, $urandom_range(3, 40));
                else if (sel == 2) wr(6'h03, $urandom_range(0, 3));
                else if (sel == 3) wr(6'h01, $urandom_range(0, 255));
                else if (sel == 4) wr(6'h04, $urandom);
                else if (sel < 7)  wr(6'($urandom_range(8, 13)), $urandom_range(0, 40));
                else               wr(6'($urandom_range(16, 21)), $urandom_range(0, 40));
            end else begin
                if ($urandom_range(0, 5) == 0) cap_in = 4'($urandom);
                cycle();
            end
            if (n % 16 == 0) begin
                logic [5:0] a = 6'($urandom_range(0, 31));
                rd(a, "R9 random read");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule